// File: doc/BRIEF.md
# Saturating Fixed-Point Accumulator Datapath

This block is the arithmetic core of a 16-bit word DSP. It keeps a 32-bit accumulator, a 16-bit multiplicand register, a 32-bit product register and a two-bit arithmetic status (a sticky overflow flag and a saturation-mode enable). The decoder next to it hands over one operation per clock: an operation code, a 16-bit data operand taken from memory, a 4-bit shift count and a 13-bit immediate. The block updates its registers on the same clock edge. It does not fetch or decode instructions, and it does not form memory addresses.

Operations come in on a plain valid strobe. There is no back-pressure: every cycle in which `op_valid` is high retires exactly one operation, and cycles in which it is low leave all state untouched. The accumulator sign and zero conditions are combinational outputs for a branch unit. The overflow flag can be set only by arithmetic. It is cleared only by the overflow-test operation, which the branch unit issues when its branch-on-overflow test succeeds.

Top module: `dsp_acc_unit`

## Requirements
- R1: After reset the accumulator, product and multiplicand registers read 0 and the status word reads 0xFEFE (overflow flag bit 15 = 1, saturation enable bit 14 = 1).
- R2: Code 1 (shifted load) writes the 16-bit operand, sign-extended to 32 bits and shifted left by `op_shift` (0 to 15), into the accumulator.
- R3: Codes 2 (shifted add) and 3 (shifted subtract) combine the accumulator with the same sign-extended, shifted operand. An add overflows when both inputs have the same sign and the sum's sign differs. A subtract overflows when the inputs differ in sign and the result's sign differs from the old accumulator. Overflow sets status bit 15. No arithmetic operation ever clears that bit.
- R4: Codes 4 (high add) and 5 (high subtract) use the operand zero-extended and placed in bits 31:16, with the overflow rules of R3.
- R5: When status bit 14 is 1 and an add or subtract overflows, the accumulator becomes 0x7FFFFFFF if the old accumulator was non-negative and 0x80000000 otherwise. When bit 14 is 0, the wrapped result is kept.
- R6: Code 21 (overflow test) clears status bit 15. Nothing else in the block changes.
- R7: Code 18 (absolute value) negates a negative accumulator and leaves a non-negative one unchanged. If bit 14 is 1 and the negated result is 0x80000000, the accumulator becomes 0x7FFFFFFF instead.
- R8: Code 13 (multiply) stores the signed product of the multiplicand register and the operand in the product register, storing 0x40000000 as 0xC0000000. Code 14 multiplies by the sign-extended 13-bit `op_imm` without that correction. Code 12 loads the multiplicand register with the operand.
- R9: Code 15 copies the product register to the accumulator. Codes 16 (accumulate product) and 17 (subtract product) follow the overflow and saturation rules of R3 and R5.
- R10: Code 9 (AND) uses the zero-extended operand, so it clears accumulator bits 31:16. Codes 10 (OR) and 11 (XOR) change only bits 15:0.
- R11: Code 6 loads the operand into bits 15:0 and clears bits 31:16. Code 7 loads the operand into bits 31:16 and clears bits 15:0. Code 8 clears the whole accumulator.
- R12: Code 19 sets status bit 14 and code 20 clears it. Status bits 13:0 always read 0x3EFE.
- R13: A cycle with `op_valid` low changes no register, whatever the other inputs carry. Code 0 is a no-operation. `acc_neg` equals accumulator bit 31, and `acc_zero` is 1 exactly when all 32 accumulator bits are 0, both without a clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One operation is retired this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| op_shift | input | 4 | Left shift for the shifted forms |
| op_data | input | 16 | Data operand |
| op_imm | input | 13 | Immediate multiplier |
| acc_out | output | 32 | Accumulator |
| treg_out | output | 16 | Multiplicand register |
| preg_out | output | 32 | Product register |
| status_word | output | 16 | Status: bit 15 overflow, bit 14 saturation enable |
| acc_neg | output | 1 | Accumulator is negative |
| acc_zero | output | 1 | Accumulator is zero |

## Verification
The hardest states to reach are the saturation corners: an overflow that occurs while saturation is enabled and the overflow flag is already clear, from each sign of the old accumulator, and absolute value applied to 0x80000000. The stimulus builds any 32-bit accumulator from the ports by loading the high half and then ORing in the low half. It clears the sticky flag with the overflow test and sets the mode with its own operation. It then sweeps corner accumulators against corner operands for every shift count in both modes, so every kind of overflow is triggered from a known state.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 5'd0,
    OP_LDSH  = 5'd1,
    OP_ADDSH = 5'd2,
    OP_SUBSH = 5'd3,
    OP_ADDHI = 5'd4,
    OP_SUBHI = 5'd5,
    OP_LDLO  = 5'd6,
    OP_LDHI  = 5'd7,
    OP_CLR   = 5'd8,
    OP_AND   = 5'd9,
    OP_OR    = 5'd10,
    OP_XOR   = 5'd11,
    OP_LDT   = 5'd12,
    OP_MUL   = 5'd13,
    OP_MULI  = 5'd14,
    OP_PMOV  = 5'd15,
    OP_PACC  = 5'd16,
    OP_PSUB  = 5'd17,
    OP_ABS   = 5'd18,
    OP_SATON = 5'd19,
    OP_SATOF = 5'd20,
    OP_OVTST = 5'd21
  } dacc_op_e;

  localparam logic [15:0] STATUS_RESET = 16'hFEFE;
endpackage

// File: rtl/dacc_operand_align.sv
module dacc_operand_align #(
  parameter int DW  = 16,
  parameter int SHW = 4
) (
  input  logic [DW-1:0]   data,
  input  logic [SHW-1:0]  shift,
  output logic [2*DW-1:0] sext_shifted,
  output logic [2*DW-1:0] high_half,
  output logic [2*DW-1:0] zero_ext
);
  localparam int AW = 2 * DW;
  logic [AW-1:0] sext;

  always_comb begin
    sext         = {{DW{data[DW-1]}}, data};
    sext_shifted = sext << shift;
    high_half    = {data, {DW{1'b0}}};
    zero_ext     = {{DW{1'b0}}, data};
  end
endmodule

// File: rtl/dacc_addsub.sv
module dacc_addsub #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic          sub,
  input  logic          sat_en,
  output logic [AW-1:0] result,
  output logic          ovf
);
  localparam logic [AW-1:0] POS_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_MIN = {1'b1, {(AW-1){1'b0}}};
  logic [AW-1:0] raw;

  always_comb begin
    raw = sub ? (a - b) : (a + b);
    if (sub) ovf = (a[AW-1] != b[AW-1]) && (raw[AW-1] != a[AW-1]);
    else     ovf = (a[AW-1] == b[AW-1]) && (raw[AW-1] != a[AW-1]);
    if (ovf && sat_en) result = a[AW-1] ? NEG_MIN : POS_MAX;
    else               result = raw;
  end
endmodule

// File: rtl/dacc_mult.sv
module dacc_mult #(
  parameter int DW   = 16,
  parameter int IMMW = 13
) (
  input  logic [DW-1:0]   mcand,
  input  logic [DW-1:0]   data,
  input  logic [IMMW-1:0] imm,
  input  logic            use_imm,
  output logic [2*DW-1:0] product
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] ODD_PROD = {2'b01, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] FIX_PROD = {2'b11, {(AW-2){1'b0}}};

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] mplier;
  logic [AW-1:0] raw;

  generate
    if (IMMW < DW) begin : g_imm_ext
      assign imm_ext = {{(DW-IMMW){imm[IMMW-1]}}, imm};
    end else begin : g_imm_cut
      assign imm_ext = imm[DW-1:0];
    end
  endgenerate

  always_comb begin
    mplier = use_imm ? imm_ext : data;
    raw = $signed({{DW{mcand[DW-1]}}, mcand}) * $signed({{DW{mplier[DW-1]}}, mplier});
    if (!use_imm && raw == ODD_PROD) product = FIX_PROD;
    else                             product = raw;
  end
endmodule

// File: rtl/dsp_acc_unit.sv
module dsp_acc_unit
  import dacc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int SHW  = 4,
  parameter int IMMW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OPW-1:0]  op_code,
  input  logic [SHW-1:0]  op_shift,
  input  logic [DW-1:0]   op_data,
  input  logic [IMMW-1:0] op_imm,
  output logic [2*DW-1:0] acc_out,
  output logic [DW-1:0]   treg_out,
  output logic [2*DW-1:0] preg_out,
  output logic [15:0]     status_word,
  output logic            acc_neg,
  output logic            acc_zero
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] POS_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_MIN = {1'b1, {(AW-1){1'b0}}};

  dacc_op_e op;
  assign op = dacc_op_e'(op_code);

  logic [AW-1:0] acc_q, acc_d, prod_q, prod_d;
  logic [DW-1:0] mc_q, mc_d;
  logic          ov_q, ov_d, sat_q, sat_d;

  logic [AW-1:0] opnd_sh, opnd_hi, opnd_zx;
  logic [AW-1:0] as_b, as_res, mul_res, neg_acc;
  logic          as_sub, as_ovf, is_arith;

  dacc_operand_align #(.DW(DW), .SHW(SHW)) align_i (
    .data(op_data), .shift(op_shift),
    .sext_shifted(opnd_sh), .high_half(opnd_hi), .zero_ext(opnd_zx)
  );

  always_comb begin
    as_sub   = 1'b0;
    as_b     = opnd_sh;
    is_arith = 1'b0;
    case (op)
      OP_ADDSH: begin is_arith = 1'b1; as_b = opnd_sh; end
      OP_SUBSH: begin is_arith = 1'b1; as_b = opnd_sh; as_sub = 1'b1; end
      OP_ADDHI: begin is_arith = 1'b1; as_b = opnd_hi; end
      OP_SUBHI: begin is_arith = 1'b1; as_b = opnd_hi; as_sub = 1'b1; end
      OP_PACC:  begin is_arith = 1'b1; as_b = prod_q; end
      OP_PSUB:  begin is_arith = 1'b1; as_b = prod_q; as_sub = 1'b1; end
      default:  ;
    endcase
  end

  dacc_addsub #(.AW(AW)) addsub_i (
    .a(acc_q), .b(as_b), .sub(as_sub), .sat_en(sat_q),
    .result(as_res), .ovf(as_ovf)
  );

  dacc_mult #(.DW(DW), .IMMW(IMMW)) mult_i (
    .mcand(mc_q), .data(op_data), .imm(op_imm),
    .use_imm(op == OP_MULI), .product(mul_res)
  );

  assign neg_acc = -acc_q;

  always_comb begin
    acc_d  = acc_q;
    prod_d = prod_q;
    mc_d   = mc_q;
    ov_d   = ov_q;
    sat_d  = sat_q;
    if (op_valid) begin
      if (is_arith) begin
        acc_d = as_res;
        if (as_ovf) ov_d = 1'b1;
      end
      case (op)
        OP_LDSH:  acc_d = opnd_sh;
        OP_LDLO:  acc_d = opnd_zx;
        OP_LDHI:  acc_d = opnd_hi;
        OP_CLR:   acc_d = '0;
        OP_AND:   acc_d = acc_q & opnd_zx;
        OP_OR:    acc_d = {acc_q[AW-1:DW], acc_q[DW-1:0] | op_data};
        OP_XOR:   acc_d = {acc_q[AW-1:DW], acc_q[DW-1:0] ^ op_data};
        OP_LDT:   mc_d  = op_data;
        OP_MUL,
        OP_MULI:  prod_d = mul_res;
        OP_PMOV:  acc_d = prod_q;
        OP_ABS: begin
          if (acc_q[AW-1])
            acc_d = (sat_q && neg_acc == NEG_MIN) ? POS_MAX : neg_acc;
        end
        OP_SATON: sat_d = 1'b1;
        OP_SATOF: sat_d = 1'b0;
        OP_OVTST: ov_d  = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      prod_q <= '0;
      mc_q   <= '0;
      ov_q   <= STATUS_RESET[15];
      sat_q  <= STATUS_RESET[14];
    end else begin
      acc_q  <= acc_d;
      prod_q <= prod_d;
      mc_q   <= mc_d;
      ov_q   <= ov_d;
      sat_q  <= sat_d;
    end
  end

  assign acc_out     = acc_q;
  assign preg_out    = prod_q;
  assign treg_out    = mc_q;
  assign status_word = {ov_q, sat_q, STATUS_RESET[13:0]};
  assign acc_neg     = acc_q[AW-1];
  assign acc_zero    = (acc_q == '0);
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker
  import dacc_pkg::*;
#(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [OPW-1:0]  op_code,
  input logic [2*DW-1:0] acc_out,
  input logic [2*DW-1:0] preg_out,
  input logic [15:0]     status_word,
  input logic            acc_neg,
  input logic            acc_zero
);
  localparam int AW = 2 * DW;

  // R3
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_word[15]) |-> $past(op_valid && op_code == OP_OVTST));

  // R12
  fill_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[13:0] == 14'h3EFE);

  // R12
  sat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SATON) |=> status_word[14]);

  // R11
  clear_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLR) |=> (acc_zero && !acc_neg));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_out) && $stable(preg_out) && $stable(status_word)));

  // R7
  abs_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ABS && status_word[14]) |=> !acc_neg);

  // R8
  prod_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preg_out != {2'b01, {(AW-2){1'b0}}});
endmodule

bind dsp_acc_unit dacc_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .acc_out(acc_out), .preg_out(preg_out), .status_word(status_word),
  .acc_neg(acc_neg), .acc_zero(acc_zero)
);

// File: tb/dsp_acc_unit_tb_top.sv
module dsp_acc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [3:0]  op_shift = '0;
  logic [15:0] op_data = '0;
  logic [12:0] op_imm = '0;
  logic [31:0] acc_out, preg_out;
  logic [15:0] treg_out, status_word;
  logic        acc_neg, acc_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_acc, m_p;
  logic [15:0] m_t;
  logic        m_ov, m_sat;

  always #2 clk = ~clk;

  dsp_acc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_shift(op_shift), .op_data(op_data), .op_imm(op_imm),
    .acc_out(acc_out), .treg_out(treg_out), .preg_out(preg_out),
    .status_word(status_word), .acc_neg(acc_neg), .acc_zero(acc_zero)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "acc", acc_out, m_acc);
    chk(tag, "status", {16'h0, status_word}, {16'h0, m_ov, m_sat, 14'h3EFE});
    chk(tag, "treg", {16'h0, treg_out}, {16'h0, m_t});
    chk(tag, "preg", preg_out, m_p);
    chk("R13", "neg", {31'h0, acc_neg}, {31'h0, m_acc[31]});
    chk("R13", "zero", {31'h0, acc_zero}, {31'h0, m_acc == 32'h0});
  endtask

  task automatic model(input int op, input logic [15:0] d, input logic [3:0] sh, input logic [12:0] im);
    logic [31:0] a, b, r, sx, pr;
    logic ovf;
    a  = m_acc;
    sx = {{16{d[15]}}, d} << sh;
    case (op)
      1: m_acc = sx;
      2, 3, 4, 5, 16, 17: begin
        b = (op == 2 || op == 3) ? sx : (op == 4 || op == 5) ? {d, 16'h0} : m_p;
        if (op == 3 || op == 5 || op == 17) begin
          r = a - b;
          ovf = (a[31] != b[31]) && (r[31] != a[31]);
        end else begin
          r = a + b;
          ovf = (a[31] == b[31]) && (r[31] != a[31]);
        end
        if (ovf) begin
          m_ov = 1'b1;
          if (m_sat) r = a[31] ? 32'h80000000 : 32'h7FFFFFFF;
        end
        m_acc = r;
      end
      6:  m_acc = {16'h0, d};
      7:  m_acc = {d, 16'h0};
      8:  m_acc = 32'h0;
      9:  m_acc = a & {16'h0, d};
      10: m_acc = {a[31:16], a[15:0] | d};
      11: m_acc = {a[31:16], a[15:0] ^ d};
      12: m_t = d;
      13: begin
        pr = $signed({{16{m_t[15]}}, m_t}) * $signed({{16{d[15]}}, d});
        m_p = (pr == 32'h40000000) ? 32'hC0000000 : pr;
      end
      14: m_p = $signed({{16{m_t[15]}}, m_t}) * $signed({{19{im[12]}}, im});
      15: m_acc = m_p;
      18: if (a[31]) begin
        r = 32'h0 - a;
        m_acc = (m_sat && r == 32'h80000000) ? 32'h7FFFFFFF : r;
      end
      19: m_sat = 1'b1;
      20: m_sat = 1'b0;
      21: m_ov = 1'b0;
      default: ;
    endcase
  endtask

  task automatic run(input string tag, input int op, input logic [15:0] d = 16'h0,
                     input logic [3:0] sh = 4'h0, input logic [12:0] im = 13'h0);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = op[4:0];
    op_data  = d;
    op_shift = sh;
    op_imm   = im;
    @(negedge clk);
    op_valid = 1'b0;
    model(op, d, sh, im);
    compare(tag);
  endtask

  task automatic set_acc(input logic [31:0] v);
    run("R11", 7, v[31:16]);
    run("R10", 10, v[15:0]);
  endtask

  logic [31:0] acc_set [9] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                               32'h40000000, 32'hC0000000, 32'h00012345, 32'hFFFF8000};
  logic [15:0] dat_set [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                               16'hFFFF, 16'h4000, 16'hC000, 16'h1234};
  logic [12:0] imm_set [5] = '{13'h0000, 13'h0001, 13'h0FFF, 13'h1000, 13'h1FFF};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_acc = 32'h0; m_p = 32'h0; m_t = 16'h0; m_ov = 1'b1; m_sat = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R6: clear sticky flag; second test with flag clear changes nothing
    run("R6", 21);
    run("R6", 21);

    // R2: shifted loads
    for (int di = 0; di < 8; di++)
      for (int s = 0; s < 16; s++)
        run("R2", 1, dat_set[di], s[3:0]);

    // R3 R5: shifted add/sub, both saturation modes, all shifts
    for (int m = 0; m < 2; m++) begin
      run("R12", m ? 19 : 20);
      for (int op = 2; op <= 3; op++)
        for (int ai = 0; ai < 9; ai++)
          for (int di = 0; di < 8; di++)
            for (int s = 0; s < 16; s++) begin
              set_acc(acc_set[ai]);
              run(m ? "R5" : "R3", op, dat_set[di], s[3:0]);
              run("R6", 21);
            end
      // R4: high-half add/sub
      for (int op = 4; op <= 5; op++)
        for (int ai = 0; ai < 9; ai++)
          for (int di = 0; di < 8; di++) begin
            set_acc(acc_set[ai]);
            run("R4", op, dat_set[di]);
            run("R3", 2, 16'h0001);
          end
      // R8 R9: products, then product move/accumulate/subtract
      for (int ti = 0; ti < 8; ti++)
        for (int di = 0; di < 8; di++) begin
          run("R8", 12, dat_set[ti]);
          run("R8", 13, dat_set[di]);
          run("R9", 15);
          for (int ai = 0; ai < 9; ai++) begin
            set_acc(acc_set[ai]);
            run("R9", 16);
            set_acc(acc_set[ai]);
            run("R9", 17);
            run("R6", 21);
          end
        end
      // R7: absolute value
      for (int ai = 0; ai < 9; ai++) begin
        set_acc(acc_set[ai]);
        run("R7", 18);
      end
    end

    // R8: immediate multiply
    for (int ti = 0; ti < 8; ti++)
      for (int ii = 0; ii < 5; ii++) begin
        run("R8", 12, dat_set[ti]);
        run("R8", 14, 16'hFFFF, 4'h0, imm_set[ii]);
      end

    // R10 R11: logical and zero-fill loads
    for (int ai = 0; ai < 9; ai++)
      for (int di = 0; di < 8; di++) begin
        for (int op = 9; op <= 11; op++) begin
          set_acc(acc_set[ai]);
          run("R10", op, dat_set[di]);
        end
        set_acc(acc_set[ai]);
        run("R11", 6, dat_set[di]);
        run("R11", 8);
      end

    // R13: idle cycles with junk inputs, then a no-operation
    set_acc(32'h89ABCDEF);
    run("R8", 12, 16'h7FFF);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
      op_code  = 5'(k + 1);
      op_data  = 16'hA5A5 ^ 16'(k);
      op_shift = k[3:0];
      op_imm   = 13'h1555;
      @(negedge clk);
      compare("R13");
    end
    run("R13", 0, 16'hFFFF, 4'hF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule